// File: doc/BRIEF.md
# Control OUT Endpoint-Zero Handshake Controller

This block holds the 32-bit control register for the receive direction of a USB device's default control endpoint. It also decides which handshake goes back for each packet the packet engine reports. Software programs the register through a single-register write port with byte strobes and reads it back at any time through a combinational read port. The packet engine supplies one-cycle event pulses. The block then returns a handshake code, a strobe that tells the receive FIFO to keep the packet, and interrupt strobes.

Software arms the endpoint, requests or withdraws NAK, requests a STALL, and can select snoop mode, in which packets that fail the CRC check are still accepted. Hardware disarms the endpoint whenever it raises an interrupt strobe. It forces NAK after a SETUP packet or a finished transfer, and it withdraws a STALL when a new SETUP token arrives. SETUP data is always acknowledged and stored.

All outputs are registered. A handshake, a FIFO write strobe or an interrupt strobe appears in the cycle after the event pulse and lasts for one cycle. The register state changes on the same clock edge.

Top module: `ep0_out_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_8000 with bits 1:0 equal to `in_mps`. `hs_code` is 0 (none), and `fifo_wr`, `irq_setup_done` and `irq_xfer_done` are all 0.
- R2: Some fields are fixed. Bit 30 (disable), bits 27 and 26 (NAK set/clear requests) and bits 19:18 (type) always read 0. Bit 15 (active) always reads 1. Bits 1:0 always show the current `in_mps` input.
- R3: Writing 1 to bit 27 sets the NAK status, which reads at bit 17. Writing 1 to bit 26 clears it. When both are written in the same write, the status ends up set.
- R4: Hardware sets the NAK status on a `setup_data` or `xfer_done` pulse. This hardware set wins over a clear request written in the same cycle.
- R5: Writing 1 to bit 21 sets STALL, and writing 0 leaves it unchanged. A `setup_tok` pulse clears STALL, and the clear wins over a set written in the same cycle.
- R6: A `setup_data` pulse is followed in the next cycle by `hs_code`=1 (ACK) and `fifo_wr`=1. This holds whatever the STALL, NAK status, `gnak` and enable state.
- R7: An `out_data` pulse with an accepted packet gets a handshake in the next cycle, chosen in this order: STALL (code 3) if STALL is set; otherwise NAK (code 2) if the NAK status or `gnak` is set, or the enable bit is 0, or `fifo_room` is 0; otherwise ACK (code 1). `fifo_wr` is 1 only with ACK.
- R8: A packet with `out_crc_ok`=0 gets no handshake (code 0) and is not written while snoop mode (bit 20) is 0. With snoop mode at 1, the packet is treated as valid.
- R9: Writing 1 to bit 31 sets the enable bit, and writing 0 leaves it unchanged. Hardware clears the enable bit on the edge that raises `irq_setup_done` (after `setup_data`) or `irq_xfer_done` (after `xfer_done`). This clear wins over a set written in the same cycle.
- R10: A write changes a field only if the strobe for its byte is 1. Bits 31, 27 and 26 are in byte 3. Bits 21 and 20 are in byte 2.
- R11: Bit 20 (snoop mode) is read/write. A write of 0 under its byte strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_wstrb | input | 4 | Byte strobes for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register value |
| setup_tok | input | 1 | SETUP token received (pulse) |
| setup_data | input | 1 | SETUP data packet received (pulse) |
| out_data | input | 1 | OUT data packet received (pulse) |
| out_crc_ok | input | 1 | CRC of the OUT packet is valid |
| xfer_done | input | 1 | Transfer complete (pulse) |
| gnak | input | 1 | Global OUT NAK level |
| fifo_room | input | 1 | Receive FIFO can take a packet |
| in_mps | input | 2 | Max-packet-size field of the IN endpoint-zero register |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| fifo_wr | output | 1 | Keep the current packet in the FIFO |
| irq_setup_done | output | 1 | SETUP-done interrupt strobe |
| irq_xfer_done | output | 1 | Transfer-complete interrupt strobe |

## Verification
The hardest states to reach from the ports are the cycles where hardware and software update the same bit at once. Examples are a clear-NAK write landing on a `xfer_done` pulse, an enable write landing on the pulse that disarms the endpoint, and a STALL write landing on a SETUP token. The bench drives the register write and the event pulse on the same falling edge, so both arrive at one rising edge, and reads the result back on the next falling edge. The handshake priority is covered separately by a table. Each table row resets the block, builds the STALL/NAK/enable/snoop state with one write, sets the FIFO and global NAK levels, and sends one packet.

// File: rtl/ep0_out_pkg.sv
package ep0_out_pkg;

   typedef enum logic [1:0] {
      HS_NONE  = 2'd0,
      HS_ACK   = 2'd1,
      HS_NAK   = 2'd2,
      HS_STALL = 2'd3
   } hs_e;

   // bit positions software relies on
   localparam int EN_BIT     = 31;
   localparam int DIS_BIT    = 30;
   localparam int SNAK_BIT   = 27;
   localparam int CNAK_BIT   = 26;
   localparam int STALL_BIT  = 21;
   localparam int SNOOP_BIT  = 20;
   localparam int NAKSTS_BIT = 17;
   localparam int ACT_BIT    = 15;

endpackage

// File: rtl/ep0_out_regs.sv
module ep0_out_regs
   import ep0_out_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int MPS_W    = 2,
   parameter bit SNOOP_EN = 1'b1,
   localparam int NBYTES  = REG_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [NBYTES-1:0] wstrb,
   input  logic [REG_W-1:0]  wdata,
   input  logic              hw_en_clr,
   input  logic              hw_nak_set,
   input  logic              hw_stall_clr,
   input  logic [MPS_W-1:0]  in_mps,
   output logic              en_q,
   output logic              nak_q,
   output logic              stall_q,
   output logic              snoop_q,
   output logic [REG_W-1:0]  rdata
);

   if (REG_W != 32) begin : g_bad_width
      $error("ep0_out_regs: REG_W must be 32");
   end
   if (MPS_W < 1 || MPS_W > 8) begin : g_bad_mps
      $error("ep0_out_regs: MPS_W out of range");
   end

   logic [REG_W-1:0] wmask;
   logic [REG_W-1:0] wset;

   for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
      assign wmask[b*8 +: 8] = {8{wr & wstrb[b]}};
   end
   assign wset = wdata & wmask;

   logic unused_wset;
   assign unused_wset = ^wset;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         nak_q   <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         if (hw_en_clr)           en_q <= 1'b0;
         else if (wset[EN_BIT])   en_q <= 1'b1;

         if (wset[SNAK_BIT] || hw_nak_set) nak_q <= 1'b1;
         else if (wset[CNAK_BIT])          nak_q <= 1'b0;

         if (hw_stall_clr)          stall_q <= 1'b0;
         else if (wset[STALL_BIT])  stall_q <= 1'b1;
      end
   end

   if (SNOOP_EN) begin : g_snoop
      always_ff @(posedge clk) begin
         if (!rst_n)
            snoop_q <= 1'b0;
         else if (wr && wstrb[SNOOP_BIT/8])
            snoop_q <= wdata[SNOOP_BIT];
      end
   end else begin : g_no_snoop
      assign snoop_q = 1'b0;
   end

   always_comb begin
      rdata             = '0;
      rdata[EN_BIT]     = en_q;
      rdata[STALL_BIT]  = stall_q;
      rdata[SNOOP_BIT]  = snoop_q;
      rdata[NAKSTS_BIT] = nak_q;
      rdata[ACT_BIT]    = 1'b1;
      rdata[MPS_W-1:0]  = in_mps;
   end

   // R9
   en_hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_en_clr |=> !en_q);
   // R4
   nak_hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_nak_set |=> nak_q);
   // R5
   stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stall_clr |=> !stall_q);
   // R5
   stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && !hw_stall_clr) |=> stall_q);

endmodule

// File: rtl/ep0_out_hs.sv
module ep0_out_hs
   import ep0_out_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic setup_data,
   input  logic out_data,
   input  logic crc_ok,
   input  logic en,
   input  logic nak,
   input  logic stall,
   input  logic snoop,
   input  logic gnak,
   input  logic room,
   output hs_e  hs_q,
   output logic wr_q
);

   hs_e  hs_d;
   logic wr_d;

   always_comb begin
      hs_d = HS_NONE;
      wr_d = 1'b0;
      if (setup_data) begin
         hs_d = HS_ACK;
         wr_d = 1'b1;
      end else if (out_data) begin
         if (!crc_ok && !snoop)      hs_d = HS_NONE;
         else if (stall)             hs_d = HS_STALL;
         else if (nak || gnak)       hs_d = HS_NAK;
         else if (!en || !room)      hs_d = HS_NAK;
         else begin
            hs_d = HS_ACK;
            wr_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= HS_NONE;
         wr_q <= 1'b0;
      end else begin
         hs_q <= hs_d;
         wr_q <= wr_d;
      end
   end

   // R6
   setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setup_data |=> (hs_q == HS_ACK && wr_q));
   // R7
   stall_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_data && !setup_data && stall && (crc_ok || snoop)) |=> hs_q == HS_STALL);
   // R7
   wr_only_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> hs_q == HS_ACK);
   // R8
   crc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_data && !setup_data && !crc_ok && !snoop) |=> (hs_q == HS_NONE && !wr_q));

endmodule

// File: rtl/ep0_out_ctrl.sv
module ep0_out_ctrl
   import ep0_out_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int MPS_W    = 2,
   parameter bit SNOOP_EN = 1'b1,
   localparam int NBYTES  = REG_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [NBYTES-1:0] reg_wstrb,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              setup_tok,
   input  logic              setup_data,
   input  logic              out_data,
   input  logic              out_crc_ok,
   input  logic              xfer_done,
   input  logic              gnak,
   input  logic              fifo_room,
   input  logic [MPS_W-1:0]  in_mps,
   output logic [1:0]        hs_code,
   output logic              fifo_wr,
   output logic              irq_setup_done,
   output logic              irq_xfer_done
);

   logic en_q, nak_q, stall_q, snoop_q;
   hs_e  hs_q;

   ep0_out_regs #(.REG_W(REG_W), .MPS_W(MPS_W), .SNOOP_EN(SNOOP_EN)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (reg_wr),
      .wstrb        (reg_wstrb),
      .wdata        (reg_wdata),
      .hw_en_clr    (setup_data | xfer_done),
      .hw_nak_set   (setup_data | xfer_done),
      .hw_stall_clr (setup_tok),
      .in_mps       (in_mps),
      .en_q         (en_q),
      .nak_q        (nak_q),
      .stall_q      (stall_q),
      .snoop_q      (snoop_q),
      .rdata        (reg_rdata)
   );

   ep0_out_hs u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup_data (setup_data),
      .out_data   (out_data),
      .crc_ok     (out_crc_ok),
      .en         (en_q),
      .nak        (nak_q),
      .stall      (stall_q),
      .snoop      (snoop_q),
      .gnak       (gnak),
      .room       (fifo_room),
      .hs_q       (hs_q),
      .wr_q       (fifo_wr)
   );

   assign hs_code = hs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_setup_done <= 1'b0;
         irq_xfer_done  <= 1'b0;
      end else begin
         irq_setup_done <= setup_data;
         irq_xfer_done  <= xfer_done;
      end
   end

   // R9
   irq_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_setup_done || irq_xfer_done) |-> !reg_rdata[EN_BIT]);
   // R6
   setup_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_setup_done |-> fifo_wr);

endmodule

// File: tb/ep0_out_ctrl_bench.sv
module ep0_out_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_wstrb = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        setup_tok = 1'b0, setup_data = 1'b0, out_data = 1'b0;
   logic        out_crc_ok = 1'b1, xfer_done = 1'b0;
   logic        gnak = 1'b0, fifo_room = 1'b1;
   logic [1:0]  in_mps = 2'd2;
   logic [1:0]  hs_code;
   logic        fifo_wr, irq_setup_done, irq_xfer_done;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ep0_out_ctrl u_ep0_out_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wstrb(reg_wstrb),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .setup_tok(setup_tok),
      .setup_data(setup_data), .out_data(out_data), .out_crc_ok(out_crc_ok),
      .xfer_done(xfer_done), .gnak(gnak), .fifo_room(fifo_room), .in_mps(in_mps),
      .hs_code(hs_code), .fifo_wr(fifo_wr), .irq_setup_done(irq_setup_done),
      .irq_xfer_done(irq_xfer_done)
   );

   // {stall nak gnak en room crc snoop}_{hs}_{wr}
   localparam logic [9:0] VEC [11] = '{
      10'b0001110_01_1,   // all clear: ACK
      10'b1101110_11_0,   // stall over nak
      10'b1011110_11_0,   // stall over global nak
      10'b0101110_10_0,   // nak status
      10'b0011110_10_0,   // global nak
      10'b0000110_10_0,   // not enabled
      10'b0001010_10_0,   // no room
      10'b0001100_00_0,   // crc bad, no snoop
      10'b0001101_01_1,   // crc bad, snoop
      10'b1000010_11_0,   // stall, disabled, no room
      10'b1001100_00_0    // crc bad beats stall
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_reg(input logic [3:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wstrb = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wstrb = '0; reg_wdata = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R7 / R8 priority table
      foreach (VEC[i]) begin
         logic [9:0] v;
         v = VEC[i];
         do_reset();
         gnak = v[7]; fifo_room = v[5];
         wr_reg(4'hF, {v[6], 3'b0, v[8], 5'b0, v[9], v[3], 20'b0});
         @(negedge clk);
         out_data = 1'b1; out_crc_ok = v[4];
         @(negedge clk);
         out_data = 1'b0; out_crc_ok = 1'b1;
         chk($sformatf("R7 R8 row%0d hs", i), {30'b0, hs_code}, {30'b0, v[2:1]});
         chk($sformatf("R7 R8 row%0d fifo_wr", i), {31'b0, fifo_wr}, {31'b0, v[0]});
      end
      gnak = 1'b0; fifo_room = 1'b1;

      // R1 reset state
      do_reset();
      @(negedge clk);
      chk("R1 rdata", reg_rdata, 32'h0000_8002);
      chk("R1 outputs", {28'b0, hs_code, fifo_wr, irq_setup_done | irq_xfer_done}, 32'h0);
      in_mps = 2'd1; #1;
      chk("R2 mps mirror", reg_rdata, 32'h0000_8001);
      in_mps = 2'd2;

      // R2 R3 R11: write all ones, set wins over clear
      wr_reg(4'hF, 32'hFFFF_FFFF);
      chk("R2 R3 R11 all ones", reg_rdata, 32'h8032_8002);
      // R5 R9 R11: zeros leave enable/stall/nak, clear snoop
      wr_reg(4'hF, 32'h0);
      chk("R5 R9 R11 zeros", reg_rdata, 32'h8022_8002);
      // R10: clear request with byte 3 strobe off
      wr_reg(4'h7, 32'h0400_0000);
      chk("R10 byte3 off", reg_rdata, 32'h8022_8002);
      // R3: clear request
      wr_reg(4'h8, 32'h0400_0000);
      chk("R3 clear nak", reg_rdata, 32'h8020_8002);
      // R10: snoop with byte 2 strobe off
      wr_reg(4'h8, 32'h0010_0000);
      chk("R10 byte2 off", reg_rdata, 32'h8020_8002);

      // R5: setup token beats simultaneous stall write
      @(negedge clk);
      setup_tok = 1'b1; reg_wr = 1'b1; reg_wstrb = 4'hF; reg_wdata = 32'h0020_0000;
      @(negedge clk);
      setup_tok = 1'b0; reg_wr = 1'b0; reg_wstrb = '0; reg_wdata = '0;
      chk("R5 token clears stall", reg_rdata, 32'h8000_8002);

      // R6 R4 R9: setup data against stall, nak, global nak
      wr_reg(4'hF, 32'h0820_0000);
      chk("R5 R3 set stall nak", reg_rdata, 32'h8022_8002);
      gnak = 1'b1; fifo_room = 1'b1;
      @(negedge clk);
      setup_data = 1'b1;
      @(negedge clk);
      setup_data = 1'b0;
      chk("R6 setup ACK", {30'b0, hs_code}, 32'd1);
      chk("R6 setup fifo_wr", {31'b0, fifo_wr}, 32'd1);
      chk("R9 irq_setup_done", {31'b0, irq_setup_done}, 32'd1);
      chk("R9 R4 after setup", reg_rdata, 32'h0022_8002);
      @(negedge clk);
      chk("R6 one-cycle strobes", {29'b0, hs_code, irq_setup_done}, 32'd0);
      gnak = 1'b0;

      // R4 R9: transfer done with simultaneous clear-nak and enable writes
      @(negedge clk);
      setup_tok = 1'b1;
      @(negedge clk);
      setup_tok = 1'b0;
      wr_reg(4'h8, 32'h8000_0000);
      chk("R9 enable set", reg_rdata, 32'h8002_8002);
      @(negedge clk);
      xfer_done = 1'b1; reg_wr = 1'b1; reg_wstrb = 4'h8; reg_wdata = 32'h8400_0000;
      @(negedge clk);
      xfer_done = 1'b0; reg_wr = 1'b0; reg_wstrb = '0; reg_wdata = '0;
      chk("R9 irq_xfer_done", {31'b0, irq_xfer_done}, 32'd1);
      chk("R4 R9 hw wins", reg_rdata, 32'h0002_8002);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule